// File: doc/BRIEF.md
# Flash-style erase sequencer with status reporting

This block sits in front of a small register-modelled storage array and behaves like the erase side of a flash device. A host talks to it with plain bus writes and reads. A fixed six-write unlock sequence either wipes one block or wipes the whole array. While the erase runs, reads no longer return array contents. They return a status byte instead, so software can poll for progress. A separate 2-bit input reports the programming-supply level, and it decides whether an erase may start and whether it may continue.

The erase time is a programmable cycle count. A test input forces the completion step to fail, so the error path can be exercised. A normal erase ends with the block back in read mode. A failed erase leaves the block reporting status until a reset command arrives. A command issued with the supply below the programming level is dropped without any trace.

Top module: `erase_ctrl`

## Requirements
- R1: An erase command is six consecutive bus writes: 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, then a final write. The final write is data 0x10 at any address for a whole-array erase, or data 0x30 for a block erase. Any mismatching write returns the sequence to its first step, and the array stays unchanged.
- R2: A whole-array erase sets every word of the array to 0xFF.
- R3: A block erase sets to 0xFF only the words of the block selected by address bits [5:4] of the final write. Every other word keeps its value.
- R4: A command is started only when `vpp_lvl` is 2'b10 at the final write. With 2'b00 or 2'b01, the command is dropped, the array is unchanged and the block stays in read mode.
- R5: While erasing, every bus write is ignored, including the reset command. Every read returns the status byte with bit 7 = 0.
- R6: The erase occupies `erase_dur`+1 cycles after the final write. Reads return status through the last of these cycles. The block then applies the erase and returns to read mode without any command.
- R7: If `force_fail` is high when the count expires, the array is left unchanged. The block enters the error state, and status reads return bit 7 = 1, bit 5 = 1 and bit 4 = 0.
- R8: If `vpp_lvl` leaves 2'b10 during an erase, the erase stops with the array unchanged. Status then shows bits 7, 5 and 4 all set.
- R9: Bit 6 of the status byte inverts on each status read in the busy or error state.
- R10: After reset the block is in read mode, `bus_rdata` is 0, and word i of the array holds i XOR 0x5A. A write of data 0xF0 at any address leaves the error state and clears a partial sequence. Nothing but reset or this write leaves the error state.
- R11: Read data appears on `bus_rdata` one clock after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Word address of a read or write |
| bus_wdata | input | 8 | Write data / command byte |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| vpp_lvl | input | 2 | Supply level: 00 low, 01 logic-high, 10 programming level |
| erase_dur | input | 16 | Erase length in cycles minus one |
| force_fail | input | 1 | Forces the erase to fail at expiry |
| bus_rdata | output | 8 | Registered array word or status byte |

## Verification
A stuck unlock step shows up on the final write: the following read returns array data where status was expected, or status where data was expected. This is visible one cycle after the next read strobe. A mode register that leaves the busy state early or late moves the edge at which reads switch from status to 0xFF by at least one cycle, so reads at `erase_dur`+1 and `erase_dur`+2 after launch pin the count exactly. A lost error flag or a sticky busy state appears in bits 7, 5 and 4 on the first status read after the event. Corruption of non-selected words appears when those addresses are read back after the erase.

// File: rtl/erase_pkg.sv
package erase_pkg;
  localparam int CMD_AW = 12;
  localparam int DQ_W   = 8;
  localparam int SEQ_LEN = 5;

  typedef enum logic [1:0] {MODE_READ, MODE_BUSY, MODE_ERROR} mode_t;

  localparam logic [1:0]      VPP_PROG  = 2'b10;
  localparam logic [DQ_W-1:0] CMD_RESET = 8'hF0;
  localparam logic [DQ_W-1:0] CMD_CHIP  = 8'h10;
  localparam logic [DQ_W-1:0] CMD_BLOCK = 8'h30;

  function automatic logic [CMD_AW-1:0] unlock_addr(input int step);
    return (step == 1 || step == 4) ? 12'h2AA : 12'h555;
  endfunction

  function automatic logic [DQ_W-1:0] unlock_data(input int step);
    case (step)
      0, 3:    return 8'hAA;
      1, 4:    return 8'h55;
      default: return 8'h80;
    endcase
  endfunction

  function automatic logic [DQ_W-1:0] init_word(input int idx);
    return DQ_W'(idx) ^ 8'h5A;
  endfunction

  function automatic logic [DQ_W-1:0] status_word(input logic done, input logic tog,
                                                  input logic err, input logic vpp_err);
    return {done, tog, err, vpp_err, 4'b0000};
  endfunction
endpackage

// File: rtl/erase_seq.sv
module erase_seq
  import erase_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              enable,
  input  logic [CMD_AW-1:0] addr,
  input  logic [DQ_W-1:0]   wdata,
  output logic              start_chip,
  output logic              start_blk
);
  localparam int STEP_W = $clog2(SEQ_LEN + 1);

  logic [STEP_W-1:0] step;
  logic              hit;
  logic              at_final;

  always_comb begin
    at_final   = (int'(step) == SEQ_LEN);
    hit        = !at_final && addr == unlock_addr(int'(step)) &&
                 wdata == unlock_data(int'(step));
    start_chip = enable && we && at_final && wdata == CMD_CHIP;
    start_blk  = enable && we && at_final && wdata == CMD_BLOCK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step <= '0;
    end else if (we && enable) begin
      if (hit) step <= step + 1'b1;
      else     step <= '0;
    end
  end
endmodule

// File: rtl/erase_engine.sv
module erase_engine
  import erase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       vpp_lvl,
  input  logic [CNT_W-1:0] erase_dur,
  input  logic             force_fail,
  input  logic             reset_cmd,
  output mode_t            mode,
  output logic             launch,
  output logic             dropped,
  output logic             fire,
  output logic             err,
  output logic             vpp_err
);
  logic [CNT_W-1:0] cnt;
  logic             vpp_ok;
  logic             expired;

  always_comb begin
    vpp_ok  = (vpp_lvl == VPP_PROG);
    expired = (cnt == '0);
    launch  = start && mode == MODE_READ && vpp_ok;
    dropped = start && mode == MODE_READ && !vpp_ok;
    fire    = mode == MODE_BUSY && vpp_ok && expired && !force_fail;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= MODE_READ;
      cnt     <= '0;
      err     <= 1'b0;
      vpp_err <= 1'b0;
    end else begin
      case (mode)
        MODE_READ: begin
          if (launch) begin
            mode    <= MODE_BUSY;
            cnt     <= erase_dur;
            err     <= 1'b0;
            vpp_err <= 1'b0;
          end
        end
        MODE_BUSY: begin
          if (!vpp_ok) begin
            mode    <= MODE_ERROR;
            err     <= 1'b1;
            vpp_err <= 1'b1;
          end else if (expired) begin
            mode <= force_fail ? MODE_ERROR : MODE_READ;
            err  <= force_fail;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (reset_cmd) begin
            mode    <= MODE_READ;
            err     <= 1'b0;
            vpp_err <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/erase_array.sv
module erase_array
  import erase_pkg::*;
#(
  parameter int ARR_AW = 6,
  parameter int BLK_AW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              erase_all,
  input  logic [BLK_AW-1:0] erase_blk,
  input  logic [ARR_AW-1:0] rd_addr,
  output logic [DQ_W-1:0]   rd_data
);
  localparam int WORDS = 1 << ARR_AW;
  localparam int BLK_SHIFT = ARR_AW - BLK_AW;

  logic [DQ_W-1:0] mem [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    localparam logic [BLK_AW-1:0] MY_BLK = BLK_AW'(i >> BLK_SHIFT);
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[i] <= init_word(i);
      else if (fire && (erase_all || erase_blk == MY_BLK))
        mem[i] <= '1;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/erase_ctrl.sv
module erase_ctrl
  import erase_pkg::*;
#(
  parameter int ARR_AW = 6,
  parameter int BLK_AW = 2,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [1:0]        vpp_lvl,
  input  logic [CNT_W-1:0]  erase_dur,
  input  logic              force_fail,
  output logic [7:0]        bus_rdata
);
  mode_t             mode;
  logic              start_chip, start_blk, cmd_start;
  logic              launch, dropped, fire, err, vpp_err;
  logic              reset_cmd;
  logic              tgt_all;
  logic [BLK_AW-1:0] tgt_blk;
  logic [DQ_W-1:0]   arr_data;
  logic              tog;

  assign cmd_start = start_chip || start_blk;
  assign reset_cmd = bus_we && bus_wdata == CMD_RESET && mode != MODE_BUSY;

  erase_seq u_seq (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .enable(mode == MODE_READ),
    .addr(bus_addr), .wdata(bus_wdata),
    .start_chip(start_chip), .start_blk(start_blk)
  );

  erase_engine #(.CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(cmd_start), .vpp_lvl(vpp_lvl),
    .erase_dur(erase_dur), .force_fail(force_fail), .reset_cmd(reset_cmd),
    .mode(mode), .launch(launch), .dropped(dropped), .fire(fire),
    .err(err), .vpp_err(vpp_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_all <= 1'b0;
      tgt_blk <= '0;
    end else if (launch) begin
      tgt_all <= start_chip;
      tgt_blk <= bus_addr[ARR_AW-1 -: BLK_AW];
    end
  end

  erase_array #(.ARR_AW(ARR_AW), .BLK_AW(BLK_AW)) u_arr (
    .clk(clk), .rst_n(rst_n), .fire(fire), .erase_all(tgt_all),
    .erase_blk(tgt_blk), .rd_addr(bus_addr[ARR_AW-1:0]), .rd_data(arr_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      tog       <= 1'b0;
    end else if (bus_re) begin
      if (mode == MODE_READ) begin
        bus_rdata <= arr_data;
      end else begin
        bus_rdata <= status_word(mode == MODE_ERROR, tog, err, vpp_err);
        tog       <= ~tog;
      end
    end
  end
endmodule

// File: rtl/erase_ctrl_chk.sv
module erase_ctrl_chk
  import erase_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       bus_we,
  input logic [7:0] bus_wdata,
  input logic       bus_re,
  input logic [7:0] bus_rdata,
  input logic [1:0] vpp_lvl,
  input mode_t      mode,
  input logic       launch,
  input logic       dropped,
  input logic       vpp_err
);
  p_launch_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> mode == MODE_BUSY);

  p_drop_stays_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dropped |=> mode == MODE_READ);

  p_busy_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && mode == MODE_BUSY) |=> bus_rdata[7] == 1'b0);

  p_error_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ERROR && !(bus_we && bus_wdata == CMD_RESET)) |=> mode == MODE_ERROR);

  p_vpp_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_BUSY && vpp_lvl != VPP_PROG) |=> (mode == MODE_ERROR && vpp_err));

  p_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && mode != MODE_READ && $past(bus_re && mode != MODE_READ))
      |=> bus_rdata[6] != $past(bus_rdata[6]));
endmodule

bind erase_ctrl erase_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .bus_re(bus_re), .bus_rdata(bus_rdata), .vpp_lvl(vpp_lvl), .mode(mode),
  .launch(launch), .dropped(dropped), .vpp_err(vpp_err)
);

// File: tb/erase_ctrl_tb.sv
`timescale 1ns/1ps
module erase_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [1:0]  vpp_lvl = 2'b10;
  logic [15:0] erase_dur = 16'd20;
  logic        force_fail = 1'b0;
  logic [7:0]  bus_rdata;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] r, r2;

  always #2.5 clk = ~clk;

  erase_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .vpp_lvl(vpp_lvl), .erase_dur(erase_dur),
    .force_fail(force_fail), .bus_rdata(bus_rdata)
  );

  // Expected power-up contents, stated independently (R10)
  function automatic logic [7:0] pwr_word(input int a);
    return 8'(a % 64) ^ 8'b0101_1010;
  endfunction

  // {op, addr, data, expect}: op 0 = write, 1 = read and compare
  localparam int NV = 18;
  localparam logic [29:0] VEC [NV] = '{
    {2'd1, 12'h005, 8'h00, 8'h5F},
    {2'd1, 12'h012, 8'h00, 8'h48},
    {2'd1, 12'h03F, 8'h00, 8'h65},
    {2'd0, 12'h555, 8'hAA, 8'h00},
    {2'd0, 12'h2AA, 8'h55, 8'h00},
    {2'd0, 12'h555, 8'h77, 8'h00},
    {2'd0, 12'h555, 8'h80, 8'h00},
    {2'd0, 12'h555, 8'hAA, 8'h00},
    {2'd0, 12'h2AA, 8'h55, 8'h00},
    {2'd0, 12'h000, 8'h10, 8'h00},
    {2'd1, 12'h020, 8'h00, 8'h7A},
    {2'd0, 12'h555, 8'hAA, 8'h00},
    {2'd0, 12'h2AA, 8'h55, 8'h00},
    {2'd0, 12'h555, 8'h80, 8'h00},
    {2'd0, 12'h555, 8'hAA, 8'h00},
    {2'd0, 12'h2AA, 8'h55, 8'h00},
    {2'd0, 12'h020, 8'h40, 8'h00},
    {2'd1, 12'h555, 8'h00, 8'h4F}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic unlock(input logic [11:0] fa, input logic [7:0] fd);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(fa, fd);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset rdata", bus_rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R10 R11: table walk, mismatches abort the sequence
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][29:28] == 2'd0) wr(VEC[i][27:16], VEC[i][15:8]);
      else begin
        rd(VEC[i][27:16], r);
        chk("R1 R11 table", r, VEC[i][7:0]);
      end
    end

    // R4: wrong supply levels drop the command
    vpp_lvl = 2'b01;
    unlock(12'h000, 8'h10);
    rd(12'h005, r); chk("R4 logic-high drop", r, pwr_word(5));
    vpp_lvl = 2'b00;
    unlock(12'h010, 8'h30);
    rd(12'h011, r); chk("R4 low drop", r, pwr_word(17));
    vpp_lvl = 2'b10;

    // R3 R5 R6 R9: block 2 erase, exact completion edge
    erase_dur = 16'd20;
    unlock(12'h020, 8'h30);
    rd(12'h020, r); chk("R5 busy status", r & 8'hB0, 8'h00);
    rd(12'h020, r2); chk("R9 toggle busy", {7'd0, r[6] ^ r2[6]}, 8'h01);
    wr(12'h000, 8'hF0);
    unlock(12'h000, 8'h10);
    repeat (20 - 9) @(negedge clk);
    rd(12'h020, r); chk("R6 status on last busy cycle", r & 8'hB0, 8'h00);
    rd(12'h020, r); chk("R6 auto return", r, 8'hFF);
    rd(12'h02F, r); chk("R3 block end", r, 8'hFF);
    rd(12'h01F, r); chk("R3 neighbour below", r, pwr_word(31));
    rd(12'h030, r); chk("R3 neighbour above", r, pwr_word(48));
    rd(12'h005, r); chk("R5 chip erase ignored while busy", r, pwr_word(5));

    // R7 R10: forced failure, sticky status, reset command
    erase_dur = 16'd5;
    force_fail = 1'b1;
    unlock(12'h000, 8'h30);
    repeat (10) @(negedge clk);
    force_fail = 1'b0;
    rd(12'h000, r); chk("R7 fail status", r & 8'hB0, 8'hA0);
    wr(12'h555, 8'hAA);
    rd(12'h000, r2); chk("R10 error sticky", r2 & 8'hB0, 8'hA0);
    chk("R9 toggle error", {7'd0, r[6] ^ r2[6]}, 8'h01);
    wr(12'h123, 8'hF0);
    rd(12'h000, r); chk("R7 array unchanged", r, pwr_word(0));

    // R8: supply lost mid-erase
    erase_dur = 16'd30;
    unlock(12'h000, 8'h10);
    repeat (3) @(negedge clk);
    vpp_lvl = 2'b01;
    @(negedge clk);
    vpp_lvl = 2'b10;
    rd(12'h005, r); chk("R8 supply error", r & 8'hB0, 8'hB0);
    wr(12'h000, 8'hF0);
    rd(12'h005, r); chk("R8 array unchanged", r, pwr_word(5));

    // R2: whole-array erase
    erase_dur = 16'd4;
    unlock(12'hABC, 8'h10);
    repeat (10) @(negedge clk);
    rd(12'h005, r); chk("R2 chip low", r, 8'hFF);
    rd(12'h03F, r); chk("R2 chip high", r, 8'hFF);
    rd(12'h000, r); chk("R2 chip first", r, 8'hFF);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule